// File: doc/BRIEF.md
# Graphics Pixel Palette Expansion Stage

This stage turns a stream of packed graphics bitmap bytes into one display value per clock. Each value holds 8-bit luma Y, 8-bit chroma U and V, and a 6-bit transparency T, which gives 64 levels of blending with video. A byte carries four pixels at 2 bits per pixel, two at 4 bits, or one at 8 bits. The byte is unpacked from its most significant end. Each pixel code then picks an entry of a 256-entry colour look-up table (CLUT).

A small remap table can sit between the pixel code and the CLUT. With it, a 2-bit or 4-bit code selects an arbitrary entry of a 256-entry palette, or of a 16-entry palette when the index is limited to four bits. The palette is loaded through a write port. A graphics box is shown while `box_active` is high, and palette writes made then are dropped. Such a write sets a sticky error flag, so software can tell that it broke the rule of reloading palettes only in blank lines between boxes.

Top module: `gfx_clut_expand`

## Requirements
- R1: During and after reset, `pix_valid`, `pix_y`, `pix_u`, `pix_v`, `pix_t` and `clut_err` are all 0, and entry i of the remap table holds the value i.
- R2: `cfg_depth` selects the pixel depth: 2'b00 is 2 bits (four pixels per byte), 2'b01 is 4 bits (two pixels), and 2'b10 or 2'b11 is 8 bits (one pixel). Pixels are taken from bit 7 downward.
- R3: `in_ready` is high when no pixel is pending or only the last pixel of the held byte remains. An accepted byte produces one pixel per clock, with no gap between bytes that arrive back to back.
- R4: The first pixel of a byte accepted at clock edge k appears on the outputs, with `pix_valid` high, after edge k+2.
- R5: When `cfg_map_en` is low or the depth is 8 bits, the pixel code, zero-extended, is the CLUT index.
- R6: When `cfg_map_en` is high at 2- or 4-bit depth, the CLUT index is the 8-bit remap table entry addressed by the pixel code. Entries are written with `tbl_we`, `tbl_addr` and `tbl_wdata`.
- R7: When `cfg_clut16` is high, bits 7:4 of the CLUT index are forced to 0, which restricts the palette to 16 entries.
- R8: A CLUT entry is packed as Y in bits 29:22, U in 21:14, V in 13:6 and T in 5:0, and these appear on `pix_y`, `pix_u`, `pix_v` and `pix_t`.
- R9: A CLUT write with `box_active` low updates the entry at that clock edge. A lookup that reads the same entry at the same edge returns the previous contents.
- R10: A CLUT write made while `box_active` is high leaves the entry unchanged.
- R11: A CLUT write made while `box_active` is high sets `clut_err` at the next edge. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Pixel depth select |
| cfg_map_en | input | 1 | Route codes through the remap table |
| cfg_clut16 | input | 1 | Limit the CLUT index to 4 bits |
| box_active | input | 1 | A graphics box is being displayed |
| in_valid | input | 1 | Packed byte available |
| in_data | input | 8 | Packed pixel byte |
| in_ready | output | 1 | Byte accepted at this edge if valid |
| tbl_we | input | 1 | Remap table write strobe |
| tbl_addr | input | 4 | Remap table entry |
| tbl_wdata | input | 8 | Remap table value |
| clut_we | input | 1 | CLUT write strobe |
| clut_addr | input | 8 | CLUT entry |
| clut_wdata | input | 30 | Packed Y/U/V/T value |
| pix_valid | output | 1 | Output pixel valid |
| pix_y | output | 8 | Luma |
| pix_u | output | 8 | Blue-difference chroma |
| pix_v | output | 8 | Red-difference chroma |
| pix_t | output | 6 | Transparency |
| clut_err | output | 1 | Sticky flag for a write attempted during a box |

## Verification
A palette write and a lookup of the same entry can land on one clock edge. The bench provokes this by rewriting the entry that a running stream of identical 8-bit pixels keeps reading. Each output is compared, cycle by cycle, against a behavioural model that reads its palette before applying that edge's write. The same comparison covers a write during a box, which meets the stream but must change nothing except the error flag.

// File: rtl/gce_pkg.sv
package gce_pkg;
  localparam int BYTE_W = 8;
  localparam int COMP_W = 8;
  localparam int TR_W   = 6;
  localparam int ENT_W  = 3 * COMP_W + TR_W;

  typedef enum logic [1:0] {
    DEPTH_2  = 2'b00,
    DEPTH_4  = 2'b01,
    DEPTH_8  = 2'b10,
    DEPTH_8B = 2'b11
  } depth_e;

  typedef struct packed {
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] u;
    logic [COMP_W-1:0] v;
    logic [TR_W-1:0]   t;
  } yuvt_t;
endpackage

// File: rtl/gce_unpack.sv
module gce_unpack
  import gce_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    depth,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  output logic          in_ready,
  output logic          code_vld,
  output logic [BW-1:0] code
);
  localparam int CNT_W = $clog2(BW / 2 + 1);

  logic [BW-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] per_byte;
  int unsigned      bits;
  logic             accept;

  always_comb begin
    unique case (depth)
      DEPTH_2: begin bits = 2; per_byte = CNT_W'(BW / 2); end
      DEPTH_4: begin bits = 4; per_byte = CNT_W'(BW / 4); end
      default: begin bits = BW; per_byte = CNT_W'(1); end
    endcase
  end

  assign code_vld = (rem_q != '0);
  assign in_ready = (rem_q <= CNT_W'(1));
  assign accept   = in_valid && in_ready;
  assign code     = sh_q >> (BW - bits);

  always_comb begin
    sh_d  = sh_q;
    rem_d = rem_q;
    if (accept) begin
      sh_d  = in_data;
      rem_d = per_byte;
    end else if (code_vld) begin
      sh_d  = sh_q << bits;
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (accept || code_vld) begin
      sh_q  <= sh_d;
      rem_q <= rem_d;
    end
  end

  assert_accept_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> code_vld);

  assert_wide_one_pixel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && depth[1]) |=> in_ready);
endmodule

// File: rtl/gce_remap.sv
module gce_remap
  import gce_pkg::*;
#(
  parameter int CODE_W = BYTE_W,
  parameter int TAW    = 4,
  parameter int IW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TAW-1:0]    waddr,
  input  logic [IW-1:0]     wdata,
  input  logic [1:0]        depth,
  input  logic              map_en,
  input  logic              narrow,
  input  logic [CODE_W-1:0] code,
  output logic [IW-1:0]     idx
);
  localparam int TN = 1 << TAW;

  logic [IW-1:0] tbl_q [TN];
  logic          use_tbl;

  for (genvar g = 0; g < TN; g++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == TAW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tbl_q[g] <= IW'(g);
      else if (hit) tbl_q[g] <= wdata;
    end
  end

  assign use_tbl = map_en && !depth[1];

  always_comb begin
    if (use_tbl) idx = tbl_q[code[TAW-1:0]];
    else         idx = IW'(code);
    if (narrow)  idx[IW-1:TAW] = '0;
  end
endmodule

// File: rtl/gce_clut.sv
module gce_clut
  import gce_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = ENT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          err
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;
  logic          wr_ok;
  logic          err_q, err_d;

  assign wr_ok = we && !lock;
  assign err_d = err_q || (we && lock);

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem_q[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign rdata = rd_q;
  assign err   = err_q;

  assert_locked_write_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> err);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

  assert_locked_entry_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> (mem_q[$past(waddr)] == $past(mem_q[waddr])));
endmodule

// File: rtl/gfx_clut_expand.sv
module gfx_clut_expand
  import gce_pkg::*;
#(
  parameter int PW  = BYTE_W,
  parameter int TAW = 4,
  parameter int CAW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_depth,
  input  logic              cfg_map_en,
  input  logic              cfg_clut16,
  input  logic              box_active,
  input  logic              in_valid,
  input  logic [PW-1:0]     in_data,
  output logic              in_ready,
  input  logic              tbl_we,
  input  logic [TAW-1:0]    tbl_addr,
  input  logic [CAW-1:0]    tbl_wdata,
  input  logic              clut_we,
  input  logic [CAW-1:0]    clut_addr,
  input  logic [ENT_W-1:0]  clut_wdata,
  output logic              pix_valid,
  output logic [COMP_W-1:0] pix_y,
  output logic [COMP_W-1:0] pix_u,
  output logic [COMP_W-1:0] pix_v,
  output logic [TR_W-1:0]   pix_t,
  output logic              clut_err
);
  logic           code_vld;
  logic [PW-1:0]  code;
  logic [CAW-1:0] idx_d, idx_q;
  logic           vld_q, out_vld_q;
  logic [ENT_W-1:0] ent;
  yuvt_t          px;

  gce_unpack #(.BW(PW)) u_unpack (
    .clk(clk), .rst_n(rst_n), .depth(cfg_depth),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .code_vld(code_vld), .code(code)
  );

  gce_remap #(.CODE_W(PW), .TAW(TAW), .IW(CAW)) u_remap (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .depth(cfg_depth), .map_en(cfg_map_en), .narrow(cfg_clut16),
    .code(code), .idx(idx_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= code_vld;
      if (code_vld) idx_q <= idx_d;
    end
  end

  gce_clut #(.AW(CAW), .DW(ENT_W)) u_clut (
    .clk(clk), .rst_n(rst_n), .lock(box_active),
    .we(clut_we), .waddr(clut_addr), .wdata(clut_wdata),
    .rd_en(vld_q), .raddr(idx_q), .rdata(ent), .err(clut_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld_q <= 1'b0;
    else        out_vld_q <= vld_q;
  end

  assign px        = yuvt_t'(ent);
  assign pix_valid = out_vld_q;
  assign pix_y     = px.y;
  assign pix_u     = px.u;
  assign pix_v     = px.v;
  assign pix_t     = px.t;

  assert_out_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> pix_valid);

  assert_narrow_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && cfg_clut16) |=> (idx_q[CAW-1:TAW] == '0));
endmodule

// File: tb/gfx_clut_expand_bench.sv
module gfx_clut_expand_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_depth;
  logic        cfg_map_en, cfg_clut16, box_active;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        tbl_we;
  logic [3:0]  tbl_addr;
  logic [7:0]  tbl_wdata;
  logic        clut_we;
  logic [7:0]  clut_addr;
  logic [29:0] clut_wdata;
  logic        pix_valid;
  logic [7:0]  pix_y, pix_u, pix_v;
  logic [5:0]  pix_t;
  logic        clut_err;

  gfx_clut_expand u_gfx_clut_expand (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0, checking = 0;
  string cur_tag = "R1";

  logic [7:0] bq[$];
  logic [29:0] mclut [256];
  logic [7:0]  mtbl [16];
  logic [7:0]  mbyte;
  int          mrem;
  bit          vb, ev, merr;
  logic [7:0]  ib;
  logic [29:0] ed;

  function automatic int depth_bits();
    return (cfg_depth == 2'b00) ? 2 : (cfg_depth == 2'b01) ? 4 : 8;
  endfunction

  function automatic logic [7:0] mmap(logic [7:0] c);
    logic [7:0] v;
    v = (cfg_map_en && depth_bits() != 8) ? mtbl[c[3:0]] : c;
    if (cfg_clut16) v = v & 8'h0F;
    return v;
  endfunction

  // behavioural model, evaluated on the inputs held since the last falling edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrem = 0; mbyte = 0; vb = 0; ev = 0; merr = 0; ib = 0; ed = 0;
      for (int i = 0; i < 16; i++) mtbl[i] = 8'(i);
    end else begin
      int b;
      bit acc;
      b = depth_bits();
      ev = vb;
      if (vb) ed = mclut[ib];
      vb = (mrem != 0);
      if (vb) ib = mmap(8'(mbyte >> (8 - b)));
      acc = in_valid && (mrem <= 1);
      if (mrem != 0) begin mbyte = mbyte << b; mrem--; end
      if (acc) begin
        mbyte = in_data; mrem = 8 / b;
        void'(bq.pop_front());
      end
      if (tbl_we) mtbl[tbl_addr] = tbl_wdata;
      if (clut_we) begin
        if (box_active) merr = 1;
        else mclut[clut_addr] = clut_wdata;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual cycle %0d, expected under 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    in_valid <= (bq.size() > 0);
    in_data  <= (bq.size() > 0) ? bq[0] : 8'h00;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) begin
      chk({cur_tag, " valid"}, 64'(pix_valid), 64'(ev));
      chk("R3 ready", 64'(in_ready), 64'(mrem <= 1));
      chk("R11 err", 64'(clut_err), 64'(merr));
      if (ev) chk({cur_tag, " R8 yuvt"}, 64'({pix_y, pix_u, pix_v, pix_t}), 64'(ed));
    end
  end

  task automatic cw(logic [7:0] a, logic [29:0] d, logic box);
    @(negedge clk);
    clut_we = 1; clut_addr = a; clut_wdata = d; box_active = box;
    @(negedge clk);
    clut_we = 0; box_active = 0;
  endtask

  task automatic tw(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic drain();
    while (bq.size() > 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic cfg(logic [1:0] d, logic m, logic n);
    drain();
    cfg_depth = d; cfg_map_en = m; cfg_clut16 = n;
  endtask

  initial begin
    rst_n = 0; cfg_depth = 2'b10; cfg_map_en = 0; cfg_clut16 = 0; box_active = 0;
    tbl_we = 0; tbl_addr = 0; tbl_wdata = 0;
    clut_we = 0; clut_addr = 0; clut_wdata = 0;
    repeat (4) @(negedge clk);
    cur_tag = "R1";
    chk("R1 valid", 64'(pix_valid), 0);
    chk("R1 yuvt", 64'({pix_y, pix_u, pix_v, pix_t}), 0);
    chk("R1 err", 64'(clut_err), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 64'({pix_valid, clut_err}), 0);
    checking = 1;

    cur_tag = "R8";
    for (int i = 0; i < 256; i++)
      cw(8'(i), {8'(i), 8'(~i), 8'(i ^ 8'h5A), 6'(i * 3)}, 0);

    cur_tag = "R1_R5";
    cfg(2'b00, 1, 0);
    bq.push_back(8'b00_01_10_11);
    drain();

    cur_tag = "R5";
    cfg(2'b10, 0, 0);
    for (int i = 0; i < 12; i++) bq.push_back(8'(i * 37 + 5));
    cfg(2'b11, 1, 0);
    for (int i = 0; i < 6; i++) bq.push_back(8'(i * 91 + 200));

    cur_tag = "R2";
    cfg(2'b01, 0, 0);
    for (int i = 0; i < 10; i++) bq.push_back(8'(i * 29 + 3));
    cfg(2'b00, 0, 0);
    for (int i = 0; i < 10; i++) bq.push_back(8'(i * 53 + 17));

    cur_tag = "R3";
    drain();
    for (int i = 0; i < 16; i++) begin
      bq.push_back(8'(i * 13));
      if (i % 5 == 4) repeat (3) @(negedge clk);
    end

    cur_tag = "R6";
    drain();
    for (int i = 0; i < 16; i++) tw(4'(i), 8'(255 - i * 7));
    cfg(2'b01, 1, 0);
    for (int i = 0; i < 8; i++) bq.push_back(8'(i * 35 + 1));
    cfg(2'b00, 1, 0);
    for (int i = 0; i < 8; i++) bq.push_back(8'(i * 71 + 9));

    cur_tag = "R7";
    cfg(2'b01, 1, 1);
    for (int i = 0; i < 8; i++) bq.push_back(8'(i * 33 + 2));
    cfg(2'b10, 0, 1);
    for (int i = 0; i < 6; i++) bq.push_back(8'(i * 45 + 130));

    cur_tag = "R4";
    cfg(2'b10, 0, 0);
    begin
      int k;
      @(posedge clk); #1;
      bq.push_back(8'h21);
      k = 0;
      do begin @(negedge clk); k++; end while (!pix_valid && k < 10);
      chk("R4 latency", 64'(k), 64'd4);
    end

    cur_tag = "R9";
    drain();
    for (int i = 0; i < 10; i++) bq.push_back(8'h55);
    repeat (4) @(negedge clk);
    cw(8'h55, 30'h2ABCDE01, 0);
    cw(8'h55, 30'h1234567F, 0);

    cur_tag = "R10";
    drain();
    for (int i = 0; i < 10; i++) bq.push_back(8'h33);
    repeat (3) @(negedge clk);
    cw(8'h33, 30'h3FFFFFFF, 1);
    @(negedge clk);
    chk("R11 flag set", 64'(clut_err), 1);
    drain();
    bq.push_back(8'h33);
    drain();
    chk("R11 flag still set", 64'(clut_err), 1);

    drain();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule